// File: doc/BRIEF.md
# Grouped Counter Drift-Correction Sequencer

This engine shifts the phase of one group of timer counters by a signed drift amount. Each group is the set of activation, deadline and sync counters that belong to one cyclic dispatcher table. Group membership comes from a bitmask per group. The engine visits the member counters in ascending index order and performs exactly one read-modify-write on each one through the counter access port of a timer array. Cells outside the group are skipped and never touched. Every read-modify-write takes the same number of cycles, and every cell receives the same correction, so the relative spacing between the group's expiry points is kept. The write-back also adds one extra tick to make up for the counter tick that passes while the cell is being updated. The result wraps modulo the round length.

A start command is normally raised by the group's sync cell, which fires after the last deadline of the round. It carries a group number and a signed drift. A negative drift can only use the time left in the round after the sync point, so it is clamped to that slack. A positive drift has no limit and is reduced modulo the round length. A protect input marks an approaching expiry point. When it is seen at a cell boundary, the engine parks in a paused state. A later resume trigger, typically the next round's sync event, makes it continue at the lowest member cell that has not yet been corrected.

State machine states: IDLE (waiting for start), SELECT (chooses the next pending member and issues its read), FETCH (captures read data), WRITE (writes the corrected value), PAUSED (parked before a protected point), DONE (one-cycle completion).

Transitions:
- IDLE→SELECT on an accepted start.
- SELECT→DONE when no member is pending.
- SELECT→PAUSED when protect is high.
- SELECT→FETCH otherwise.
- FETCH→WRITE always.
- WRITE→SELECT while members remain.
- WRITE→DONE after the last member.
- PAUSED→SELECT on resume.
- DONE→IDLE always.

Top module: `drift_seq`

## Requirements
- R1: After reset, busy_o, paused_o, done_o, cnt_rd_en_o and cnt_wr_en_o are all 0, and no counter access occurs while busy_o is 0.
- R2: A start_i seen in IDLE selects membership group_masks_i[g*NCELLS +: NCELLS] for g = start_group_i. Each member cell (mask bit = 1) receives exactly one read and one write. Non-member cells are never accessed and keep their values.
- R3: The written value is (old + d + 1) mod ROUND_LEN, where old is the value read and d is the effective drift. The value written is always below ROUND_LEN.
- R4: The effective drift is max(start_drift_i, -(ROUND_LEN - SYNC_POINT)) for negative drifts, for example -50 for a round of 1000 with the sync point at 950. A positive drift of any size is taken modulo ROUND_LEN.
- R5: Cells are processed in ascending index order. Each read-modify-write asserts cnt_rd_en_o in one cycle and cnt_wr_en_o to the same address exactly two cycles later, so each member cell costs exactly 3 cycles. When start_i is high in cycle 0, the n-th write (n from 1) occurs in cycle 3n.
- R6: done_o is a one-cycle pulse in the cycle after the last write. busy_o falls in the following cycle.
- R7: start_i is ignored while busy_o is 1, including in the paused state. The running correction, its group and its drift are unchanged, and only one done_o pulse results.
- R8: protect_i high at a cell boundary (SELECT state) prevents the next read and moves the engine to PAUSED (paused_o = 1, busy_o = 1, no counter access). A resume_i pulse continues with the lowest member not yet written. Cells already corrected are not written again.
- R9: A group whose mask is all zeros produces a done_o pulse in cycle 2 after start, with no counter access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a correction (accepted in IDLE only) |
| start_group_i | input | GRP_W | Group number for the correction |
| start_drift_i | input | DRIFT_W | Signed drift in counter ticks |
| group_masks_i | input | NGROUPS*NCELLS | Membership bitmask per group, group g at bits g*NCELLS +: NCELLS |
| protect_i | input | 1 | Protected point near: stop at the next cell boundary |
| resume_i | input | 1 | Continue a paused correction |
| cnt_rd_en_o | output | 1 | Counter read request |
| cnt_wr_en_o | output | 1 | Counter write strobe |
| cnt_addr_o | output | CELL_W | Cell index for read or write |
| cnt_rd_data_i | input | CNT_W | Counter read data, valid one cycle after the read request |
| cnt_wr_data_o | output | CNT_W | Corrected counter value |
| busy_o | output | 1 | Correction in progress (also while paused) |
| paused_o | output | 1 | Parked before a protected point |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with 8 cells, 4 groups, 16-bit counters and drift, a round of 1000 and a sync point at 950. This gives a negative slack of 50, so the clamp, the wrap below zero and the wrap past 999 all fall within ordinary test values. Four groups with disjoint, interleaved and empty masks cover skipping of non-members, an empty walk, and a pause that lands between two non-adjacent members. A bench model of the timer array answers reads one cycle later, so the fixed three-cycle cost per cell and the ascending order can be checked against cycle counts taken from the start pulse.

// File: rtl/drift_seq_pkg.sv
package drift_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_FETCH,
        ST_WRITE,
        ST_PAUSED,
        ST_DONE
    } dseq_state_e;

endpackage

// File: rtl/drift_seq_prep.sv
// Turns the requested signed drift into a non-negative per-cell step:
// clamp the negative side to the slack after the sync point, reduce
// modulo the round, then add the one tick lost during the update.
module drift_seq_prep #(
    parameter int DRIFT_W    = 16,
    parameter int CNT_W      = 16,
    parameter int ROUND_LEN  = 1000,
    parameter int SYNC_POINT = 950
) (
    input  logic signed [DRIFT_W-1:0] drift_i,
    output logic        [CNT_W-1:0]   step_o
);
    localparam int NEG_SLACK = ROUND_LEN - SYNC_POINT;

    int d_ext;
    int d_eff;
    int d_mod;
    int d_step;

    always_comb begin
        d_ext  = 32'(drift_i);
        d_eff  = (d_ext < -NEG_SLACK) ? -NEG_SLACK : d_ext;
        d_mod  = (d_eff < 0) ? (d_eff + ROUND_LEN) : (d_eff % ROUND_LEN);
        d_step = (d_mod == ROUND_LEN - 1) ? 0 : (d_mod + 1);
        step_o = CNT_W'(d_step);
    end

endmodule

// File: rtl/drift_seq_pick.sv
// Lowest-index pending cell finder.
module drift_seq_pick #(
    parameter int NCELLS = 8,
    parameter int CELL_W = 3
) (
    input  logic [NCELLS-1:0] pend_i,
    output logic [CELL_W-1:0] idx_o,
    output logic              any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |pend_i;
        for (int i = NCELLS - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = CELL_W'(i);
            end
        end
    end

endmodule

// File: rtl/drift_seq_modadd.sv
// Adds a step below ROUND_LEN to a counter value, wrapping at ROUND_LEN.
module drift_seq_modadd #(
    parameter int CNT_W     = 16,
    parameter int ROUND_LEN = 1000
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic [CNT_W-1:0] step_i,
    output logic [CNT_W-1:0] sum_o
);
    localparam logic [CNT_W:0] ROUND_EXT = (CNT_W + 1)'(ROUND_LEN);

    logic [CNT_W:0] raw;

    always_comb begin
        raw = {1'b0, val_i} + {1'b0, step_i};
        if (raw >= ROUND_EXT) begin
            raw = raw - ROUND_EXT;
        end
        sum_o = raw[CNT_W-1:0];
    end

endmodule

// File: rtl/drift_seq.sv
module drift_seq
    import drift_seq_pkg::*;
#(
    parameter int NCELLS     = 8,
    parameter int NGROUPS    = 4,
    parameter int CNT_W      = 16,
    parameter int DRIFT_W    = 16,
    parameter int ROUND_LEN  = 1000,
    parameter int SYNC_POINT = 950,
    localparam int CELL_W    = (NCELLS > 1) ? $clog2(NCELLS) : 1,
    localparam int GRP_W     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [GRP_W-1:0]           start_group_i,
    input  logic signed [DRIFT_W-1:0]  start_drift_i,
    input  logic [NGROUPS*NCELLS-1:0]  group_masks_i,
    input  logic                       protect_i,
    input  logic                       resume_i,
    output logic                       cnt_rd_en_o,
    output logic                       cnt_wr_en_o,
    output logic [CELL_W-1:0]          cnt_addr_o,
    input  logic [CNT_W-1:0]           cnt_rd_data_i,
    output logic [CNT_W-1:0]           cnt_wr_data_o,
    output logic                       busy_o,
    output logic                       paused_o,
    output logic                       done_o
);

    dseq_state_e state_q, state_d;

    logic [NCELLS-1:0] pend_q;
    logic [NCELLS-1:0] pend_left;
    logic [CNT_W-1:0]  step_q;
    logic [CNT_W-1:0]  step_new;
    logic [CELL_W-1:0] cur_q;
    logic [CNT_W-1:0]  rd_q;
    logic [CNT_W-1:0]  wr_val;
    logic [CELL_W-1:0] next_idx;
    logic              any_pend;
    logic [NCELLS-1:0] sel_mask;
    logic              issue_rd;

    // Unpack the flat membership vector into one mask per group.
    logic [NCELLS-1:0] grp_tbl [NGROUPS];
    generate
        for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
            assign grp_tbl[g] = group_masks_i[g*NCELLS +: NCELLS];
        end
    endgenerate

    always_comb begin
        if (int'(start_group_i) < NGROUPS) begin
            sel_mask = grp_tbl[start_group_i];
        end else begin
            sel_mask = '0;
        end
    end

    drift_seq_prep #(
        .DRIFT_W   (DRIFT_W),
        .CNT_W     (CNT_W),
        .ROUND_LEN (ROUND_LEN),
        .SYNC_POINT(SYNC_POINT)
    ) u_prep (
        .drift_i(start_drift_i),
        .step_o (step_new)
    );

    drift_seq_pick #(
        .NCELLS(NCELLS),
        .CELL_W(CELL_W)
    ) u_pick (
        .pend_i(pend_q),
        .idx_o (next_idx),
        .any_o (any_pend)
    );

    drift_seq_modadd #(
        .CNT_W    (CNT_W),
        .ROUND_LEN(ROUND_LEN)
    ) u_add (
        .val_i (rd_q),
        .step_i(step_q),
        .sum_o (wr_val)
    );

    assign pend_left = pend_q & ~(NCELLS'(1) << cur_q);
    assign issue_rd  = (state_q == ST_SELECT) && any_pend && !protect_i;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SELECT;
                end
            end
            ST_SELECT: begin
                if (!any_pend) begin
                    state_d = ST_DONE;
                end else if (protect_i) begin
                    state_d = ST_PAUSED;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (pend_left == '0) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_SELECT;
                end
            end
            ST_PAUSED: begin
                if (resume_i) begin
                    state_d = ST_SELECT;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Working registers: pending set, step, current cell, read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            step_q <= '0;
            cur_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                pend_q <= sel_mask;
                step_q <= step_new;
            end
            if (issue_rd) begin
                cur_q <= next_idx;
            end
            if (state_q == ST_FETCH) begin
                rd_q <= cnt_rd_data_i;
            end
            if (state_q == ST_WRITE) begin
                pend_q <= pend_left;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy_o        = (state_q != ST_IDLE);
        paused_o      = (state_q == ST_PAUSED);
        done_o        = (state_q == ST_DONE);
        cnt_rd_en_o   = issue_rd;
        cnt_wr_en_o   = (state_q == ST_WRITE);
        cnt_addr_o    = (state_q == ST_SELECT) ? next_idx : cur_q;
        cnt_wr_data_o = wr_val;
    end

endmodule

// File: rtl/drift_seq_chk.sv
module drift_seq_chk #(
    parameter int CELL_W    = 3,
    parameter int CNT_W     = 16,
    parameter int ROUND_LEN = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_rd_en_o,
    input logic              cnt_wr_en_o,
    input logic [CELL_W-1:0] cnt_addr_o,
    input logic [CNT_W-1:0]  cnt_wr_data_o,
    input logic              busy_o,
    input logic              paused_o,
    input logic              done_o
);
    logic [CELL_W-1:0] last_wr;
    logic              have_wr;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            have_wr <= 1'b0;
            last_wr <= '0;
        end else if (cnt_wr_en_o) begin
            have_wr <= 1'b1;
            last_wr <= cnt_addr_o;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cnt_rd_en_o && !cnt_wr_en_o && !paused_o && !done_o)); // R1

    AST_WR_IN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en_o |-> (cnt_wr_data_o < CNT_W'(ROUND_LEN))); // R3

    AST_RMW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en_o |-> ($past(cnt_rd_en_o, 2) && cnt_addr_o == $past(cnt_addr_o, 2))); // R5

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd_en_o && have_wr) |-> (cnt_addr_o > last_wr)); // R5

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_rd_en_o && cnt_wr_en_o)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R6

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        paused_o |-> (busy_o && !cnt_rd_en_o && !cnt_wr_en_o)); // R8

endmodule

bind drift_seq drift_seq_chk #(
    .CELL_W   (CELL_W),
    .CNT_W    (CNT_W),
    .ROUND_LEN(ROUND_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_rd_en_o  (cnt_rd_en_o),
    .cnt_wr_en_o  (cnt_wr_en_o),
    .cnt_addr_o   (cnt_addr_o),
    .cnt_wr_data_o(cnt_wr_data_o),
    .busy_o       (busy_o),
    .paused_o     (paused_o),
    .done_o       (done_o)
);

// File: tb/drift_seq_test.sv
module drift_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 8;
    localparam int NG   = 4;
    localparam int ROUND = 1000;
    localparam int SYNC  = 950;
    localparam int SLACK = ROUND - SYNC;
    // Group masks: g0 = 0F, g1 = F0, g2 = A5, g3 = empty.
    localparam logic [NG*NC-1:0] MASKS = 32'h00A5F00F;
    // Vector table: {group, drift}.
    localparam int NVEC = 6;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 16'd10},
        {2'd1, 16'hFFEC},  // -20
        {2'd2, 16'd0},
        {2'd2, 16'hFFCE},  // -50 (exact slack)
        {2'd1, 16'hFED4},  // -300 (clamped)
        {2'd0, 16'd2500}   // large positive
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  start_group_i = '0;
    logic signed [15:0] start_drift_i = '0;
    logic        protect_i = 1'b0;
    logic        resume_i = 1'b0;
    logic        cnt_rd_en_o, cnt_wr_en_o, busy_o, paused_o, done_o;
    logic [2:0]  cnt_addr_o;
    logic [15:0] cnt_rd_data_i = '0;
    logic [15:0] cnt_wr_data_o;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    logic [15:0] mem [NC];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int hits [NC];
    int order [NC];
    int snap [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    drift_seq #(
        .NCELLS(NC), .NGROUPS(NG), .CNT_W(16), .DRIFT_W(16),
        .ROUND_LEN(ROUND), .SYNC_POINT(SYNC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .start_group_i(start_group_i), .start_drift_i(start_drift_i),
        .group_masks_i(MASKS), .protect_i(protect_i), .resume_i(resume_i),
        .cnt_rd_en_o(cnt_rd_en_o), .cnt_wr_en_o(cnt_wr_en_o),
        .cnt_addr_o(cnt_addr_o), .cnt_rd_data_i(cnt_rd_data_i),
        .cnt_wr_data_o(cnt_wr_data_o), .busy_o(busy_o),
        .paused_o(paused_o), .done_o(done_o)
    );

    // Timer array model: read data one cycle after the request.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cnt_rd_en_o) begin
            cnt_rd_data_i <= mem[cnt_addr_o];
            rd_cnt = rd_cnt + 1;
        end
        if (cnt_wr_en_o) begin
            mem[cnt_addr_o] <= cnt_wr_data_o;
            if (wr_cnt < NC) order[wr_cnt] = int'(cnt_addr_o);
            hits[cnt_addr_o] = hits[cnt_addr_o] + 1;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errs = errs + 1;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary_and_end();
        end
    end

    task automatic check(string tag, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errs = errs + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_val(int v, int d);
        int e;
        int r;
        e = (d < -SLACK) ? -SLACK : d;
        r = (v + e + 1) % ROUND;
        if (r < 0) r = r + ROUND;
        return r;
    endfunction

    task automatic load(int seed);
        for (int i = 0; i < NC; i++) begin
            mem[i] = 16'((i * 137 + seed * 61 + 900) % ROUND);
            snap[i] = int'(mem[i]);
            hits[i] = 0;
            order[i] = -1;
        end
        wr_cnt = 0;
        rd_cnt = 0;
    endtask

    // Pulse start for one cycle, then wait for done. Returns the cycle of done
    // counted from the start cycle (0).
    task automatic run_corr(int g, int d, output int done_at);
        done_at = -1;
        start_group_i = 2'(g);
        start_drift_i = 16'(d);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k < 200; k++) begin
            if (done_o) begin
                done_at = k;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_group(string tag, int g, int d);
        logic [NC-1:0] m;
        int n;
        m = MASKS[g*NC +: NC];
        n = 0;
        for (int i = 0; i < NC; i++) begin
            if (m[i]) begin
                n++;
                check(tag, int'(mem[i]), exp_val(snap[i], d));
            end else begin
                check(tag, int'(mem[i]), snap[i]);
            end
        end
        check(tag, wr_cnt, n);
    endtask

    initial begin
        int done_at;
        int first_wr;
        int last_wr;
        int dones;
        for (int i = 0; i < NC; i++) begin
            mem[i] = '0;
            hits[i] = 0;
            order[i] = -1;
            snap[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy_o), 0);
        check("R1 paused", int'(paused_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 access", int'(cnt_rd_en_o | cnt_wr_en_o), 0);

        // Vector table: R2 membership, R3 arithmetic, R4 clamp and modulo
        for (int k = 0; k < NVEC; k++) begin
            int g;
            int d;
            g = int'(VEC[k][17:16]);
            d = int'($signed(VEC[k][15:0]));
            load(k);
            run_corr(g, d, done_at);
            check_group("R2/R3/R4 vector", g, d);
        end

        // R5/R6: timing of group 0 (cells 0..3)
        load(7);
        first_wr = -1;
        last_wr = -1;
        done_at = -1;
        start_group_i = 2'd0;
        start_drift_i = 16'sd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k < 40; k++) begin
            if (cnt_wr_en_o) begin
                if (first_wr < 0) first_wr = k;
                last_wr = k;
            end
            if (done_o && done_at < 0) done_at = k;
            @(negedge clk);
        end
        check("R5 first write cycle", first_wr, 3);
        check("R5 last write cycle", last_wr, 12);
        check("R6 done cycle", done_at, 13);
        check("R6 busy after done", int'(busy_o), 0);
        for (int i = 0; i < 4; i++) check("R5 ascending order", order[i], i);
        check_group("R3 timing run", 0, 3);

        // R9: empty group
        load(8);
        run_corr(3, 17, done_at);
        check("R9 done cycle", done_at, 2);
        check("R9 reads", rd_cnt, 0);
        check("R9 writes", wr_cnt, 0);

        // R3/R4 wrap corners on cell 0 (group 2 contains cell 0)
        load(9);
        mem[0] = 16'd999; snap[0] = 999;
        run_corr(2, 5, done_at);
        check("R3 wrap above round", int'(mem[0]), 5);
        load(10);
        mem[0] = 16'd10; snap[0] = 10;
        run_corr(2, -50, done_at);
        check("R3 wrap below zero", int'(mem[0]), 961);
        load(11);
        mem[0] = 16'd10; snap[0] = 10;
        run_corr(2, -51, done_at);
        check("R4 clamp just past slack", int'(mem[0]), 961);

        // R7: start while busy is ignored
        load(12);
        dones = 0;
        start_group_i = 2'd0;
        start_drift_i = 16'sd10;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_group_i = 2'd1;
        start_drift_i = 16'sd20;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (done_o) dones++;
            @(negedge clk);
        end
        check("R7 single done", dones, 1);
        check_group("R7 original group kept", 0, 10);

        // R8: pause at a boundary, then resume (group 2: cells 0,2,5,7)
        load(13);
        start_group_i = 2'd2;
        start_drift_i = 16'sd7;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (wr_cnt == 2) begin
                protect_i = 1'b1;
                break;
            end
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R8 paused", int'(paused_o), 1);
        check("R8 busy while paused", int'(busy_o), 1);
        check("R8 writes held", wr_cnt, 2);
        // start during pause must be ignored (R7)
        start_group_i = 2'd1;
        start_drift_i = 16'sd40;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        protect_i = 1'b0;
        @(negedge clk);
        check("R7 still paused after start", int'(paused_o), 1);
        resume_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 finished", int'(busy_o), 0);
        check("R8 cell 5 once", hits[5], 1);
        check("R8 cell 0 once", hits[0], 1);
        check("R8 resume order", order[2], 5);
        check_group("R8 values", 2, 7);

        summary_and_end();
    end

endmodule